// File: doc/BRIEF.md
# I2C Register-Access Slave with Auto-Incrementing Pointer

This block is a bus slave for a two-wire serial bus (I2C/SMBus). A host reaches a small byte-wide register file through it. The bus address has seven bits. The top five bits are a fixed prefix, `10010` by default. The bottom two bits come from two strap pins, which the block captures once, right after reset. The block follows SCL and SDA through a synchronizer clocked by the system clock. It recognises start, repeated start and stop conditions, and it acknowledges only its own address. It drives SDA only through an active-low enable, and it changes that enable only while SCL is low.

An internal register pointer selects the register for each access. In a write transaction, the first byte after the address always loads the pointer. Each later byte is stored at the pointer, and the pointer then moves on by one. In a read transaction, the register at the pointer is shifted out. The pointer moves on each time the master acknowledges a byte, and a NACK from the master ends the read. The pointer wraps from the last register back to zero.

Register 0 holds event flags. Logic inside the chip sets them, and the host clears them by writing ones. While any flag is set, the block pulls its open-drain alert line low.

Top module: `i2c_ptr_regfile`

## Requirements
- R1: The block acknowledges an address byte by pulling SDA low in the ninth clock only when the upper seven bits equal {`10010`, strap[1:0]}. Bit 0 of the address byte is 0 for a write and 1 for a read. Any other address gets no acknowledge, and the block leaves SDA released until the next start condition.
- R2: The strap pins are captured in the first clock after reset is released. Later changes on them have no effect on the address the block answers to.
- R3: The first byte after a write address loads the pointer from its low log2(NUM_REGS) bits, and the upper bits are ignored. A write that carries only this byte changes no register.
- R4: Each further write byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: A read returns the register at the pointer, most significant bit first. The pointer advances after each byte the master acknowledges. After a master NACK the block releases SDA and does not advance the pointer.
- R6: The pointer is 0 after reset and wraps from NUM_REGS-1 to 0, on both writes and reads.
- R7: A repeated start begins a new transaction with a fresh address byte, and the pointer keeps its value.
- R8: Register 0 holds event flags. A 1 on event_i bit k sets flag k, and a host write of a 1 to bit k clears it. If both happen in the same clock, the set wins. alert_oe_o is 1 while any flag is set.
- R9: After reset, sda_oe_o and alert_oe_o are 0 and all registers are 0. sda_oe_o changes only while the synchronized SCL is low.
- R10: regs_o shows register i on bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level on the bus |
| sda_i | input | 1 | SDA level on the bus |
| strap_i | input | 2 | Strap pins giving the low two address bits |
| event_i | input | 8 | Event pulses that set the flags in register 0 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| alert_oe_o | output | 1 | 1 pulls the open-drain alert line low |
| regs_o | output | NUM_REGS*8 | Register file contents |

## Verification
The assertions check four rules on every cycle:
- the SDA enable only moves while the synchronized SCL is low;
- an event pulse raises the alert in the next clock;
- each stored byte advances the pointer by exactly one, wrapping at the top;
- the captured strap value never changes after the first clock.

Address matching and rejection, and the pointer load taking the place of a data write, can only be shown by the bench's bus transactions. The same holds for read data order, ACK/NACK-controlled pointer advance, repeated start and clearing flags by writing ones.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } xfer_state_t;

endpackage

// File: rtl/i2cp_line_sync.sv
module i2cp_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // index 0 is the newest sample; index SYNC_STAGES is one clock of history
    localparam int LAST = SYNC_STAGES;

    typedef struct packed {
        logic [LAST:0] scl;
        logic [LAST:0] sda;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d     = q;
        d.scl = {q.scl[LAST-1:0], scl_i};
        d.sda = {q.sda[LAST-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;

    assign scl_now = q.scl[LAST-1];
    assign scl_old = q.scl[LAST];
    assign sda_now = q.sda[LAST-1];
    assign sda_old = q.sda[LAST];

    assign scl_s_o    = scl_now;
    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/i2cp_xfer_engine.sv
module i2cp_xfer_engine
    import i2cp_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter logic [4:0] ADDR_PREFIX = 5'b10010,
    localparam int        PTR_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_s_i,
    input  logic [1:0]        strap_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [1:0]        strap_o,
    output logic              strap_ok_o
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [3:0] LAST_TX_BIT   = 4'd7;

    typedef struct packed {
        xfer_state_t       st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              rd_mode;
        logic              ptr_phase;
        logic              host_ack;
        logic              oe;
        logic [PTR_W-1:0]  ptr;
        logic [1:0]        strap;
        logic              strap_ok;
    } eng_t;

    eng_t q, d;
    logic addr_hit;
    logic wr_en;

    assign addr_hit = (q.rx[BYTE_W-1:1] == {ADDR_PREFIX, q.strap});

    always_comb begin
        d     = q;
        wr_en = 1'b0;

        if (!q.strap_ok) begin
            d.strap    = strap_i;
            d.strap_ok = 1'b1;
        end

        if (start_i) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.rx  = {q.rx[BYTE_W-2:0], sda_s_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == BITS_PER_BYTE) begin
                        if (addr_hit) begin
                            d.oe      = 1'b1;
                            d.rd_mode = q.rx[0];
                            d.st      = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.rd_mode) begin
                            d.tx = rd_data_i;
                            d.oe = ~rd_data_i[BYTE_W-1];
                            d.st = ST_RD_BYTE;
                        end else begin
                            d.oe        = 1'b0;
                            d.ptr_phase = 1'b1;
                            d.st        = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise_i) begin
                        d.rx  = {q.rx[BYTE_W-2:0], sda_s_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == BITS_PER_BYTE) begin
                        d.oe        = 1'b1;
                        d.st        = ST_WR_ACK;
                        d.ptr_phase = 1'b0;
                        if (q.ptr_phase) begin
                            d.ptr = q.rx[PTR_W-1:0];
                        end else begin
                            wr_en = 1'b1;
                            d.ptr = q.ptr + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall_i) begin
                        if (q.cnt == LAST_TX_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_RD_ACK;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.oe  = ~q.tx[BYTE_W-2];
                            d.tx  = {q.tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        d.host_ack = ~sda_s_i;
                        if (!sda_s_i) begin
                            d.ptr = q.ptr + 1'b1;
                        end
                    end else if (scl_fall_i) begin
                        if (q.host_ack) begin
                            d.tx  = rd_data_i;
                            d.oe  = ~rd_data_i[BYTE_W-1];
                            d.cnt = '0;
                            d.st  = ST_RD_BYTE;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign wr_en_o    = wr_en;
    assign wr_data_o  = q.rx;
    assign ptr_o      = q.ptr;
    assign strap_o    = q.strap;
    assign strap_ok_o = q.strap_ok;

endmodule

// File: rtl/i2cp_reg_store.sv
module i2cp_reg_store
    import i2cp_pkg::*;
#(
    parameter int  NUM_REGS = 8,
    localparam int PTR_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [PTR_W-1:0]           addr_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    input  logic [BYTE_W-1:0]          event_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic                       alert_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q, regs_d;
    logic [BYTE_W-1:0]               clr_mask;

    always_comb begin
        regs_d   = regs_q;
        clr_mask = (wr_en_i && addr_i == '0) ? wr_data_i : '0;
        // flags: clear by writing ones; a new event wins over a clear
        regs_d[0] = (regs_q[0] & ~clr_mask) | event_i;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (wr_en_i && addr_i == PTR_W'(i)) begin
                regs_d[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data_o  = regs_q[addr_i];
    assign alert_oe_o = |regs_q[0];
    assign regs_o     = regs_q;

endmodule

// File: rtl/i2c_ptr_regfile.sv
module i2c_ptr_regfile
    import i2cp_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter logic [4:0] ADDR_PREFIX = 5'b10010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic [1:0]                 strap_i,
    input  logic [BYTE_W-1:0]          event_i,
    output logic                       sda_oe_o,
    output logic                       alert_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int PTR_W = $clog2(NUM_REGS);

    logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic [PTR_W-1:0]  cur_ptr;
    logic [1:0]        strap_q;
    logic              strap_ok;

    i2cp_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s_o   (scl_s),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (bus_start),
        .stop_o    (bus_stop)
    );

    i2cp_xfer_engine #(
        .NUM_REGS   (NUM_REGS),
        .ADDR_PREFIX(ADDR_PREFIX)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .start_i   (bus_start),
        .stop_i    (bus_stop),
        .sda_s_i   (sda_s),
        .strap_i   (strap_i),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .ptr_o     (cur_ptr),
        .strap_o   (strap_q),
        .strap_ok_o(strap_ok)
    );

    i2cp_reg_store #(
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (cur_ptr),
        .wr_data_i (wr_data),
        .event_i   (event_i),
        .rd_data_o (rd_data),
        .alert_oe_o(alert_oe_o),
        .regs_o    (regs_o)
    );

endmodule

// File: rtl/i2c_ptr_regfile_chk.sv
module i2c_ptr_regfile_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic [7:0]       event_i,
    input logic             alert_oe,
    input logic             wr_en,
    input logic [PTR_W-1:0] ptr,
    input logic [1:0]       strap,
    input logic             strap_ok
);

    // R9: the SDA enable only moves while the synchronized SCL is low
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R8: any event pulse pulls the alert line in the next clock
    a_r8_event_raises_alert: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> alert_oe);

    // R4: every stored byte advances the pointer by one
    a_r4_ptr_steps_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + PTR_W'(1)));

    // R6: the pointer wraps from the top register to zero
    a_r6_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == '1) |=> (ptr == '0));

    // R2: the captured strap value is frozen once taken
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ok |=> ($stable(strap) && strap_ok));

endmodule

bind i2c_ptr_regfile i2c_ptr_regfile_chk #(.PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe_o),
    .event_i (event_i),
    .alert_oe(alert_oe_o),
    .wr_en   (wr_en),
    .ptr     (cur_ptr),
    .strap   (strap_q),
    .strap_ok(strap_ok)
);

// File: tb/i2c_ptr_regfile_test.sv
`timescale 1ns/1ps
module i2c_ptr_regfile_test;

    localparam int NREG = 8;
    localparam int H    = 20;   // clocks per half SCL period

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic [1:0]      strap = 2'b10;
    logic [7:0]      event_in = 8'h00;
    logic            sda_oe, alert_oe;
    logic [NREG*8-1:0] regs;
    logic            sda_bus;

    int checks = 0;
    int errors = 0;
    int scl_hi_moves = 0;
    bit done = 0;
    logic [7:0] model [NREG];

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_ptr_regfile #(.NUM_REGS(NREG)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .strap_i   (strap),
        .event_i   (event_in),
        .sda_oe_o  (sda_oe),
        .alert_oe_o(alert_oe),
        .regs_o    (regs)
    );

    // R9 monitor: the enable must never move while SCL is high on the bus
    logic sda_oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== sda_oe_prev && scl_m) scl_hi_moves++;
        sda_oe_prev <= sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(H);
            scl_m = 1'b1; hold(H);
            scl_m = 1'b0; hold(2);
        end
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H/2);
        ack = (sda_bus == 1'b0);
        hold(H/2);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(H);
            scl_m = 1'b1; hold(H/2);
            b[i] = sda_bus;
            hold(H/2);
            scl_m = 1'b0; hold(2);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; hold(H);
        scl_m = 1'b1; hold(H);
        scl_m = 1'b0; hold(2);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] reg_at(input int i);
        return regs[8*i +: 8];
    endfunction

    task automatic check_all_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, {24'h0, reg_at(i)}, {24'h0, model[i]});
    endtask

    task automatic t_reset();
        chk("R9 reset sda_oe", {31'h0, sda_oe}, 0);
        chk("R9 reset alert", {31'h0, alert_oe}, 0);
        chk("R9 reset regs", regs[31:0], 0);
        chk("R10 reset regs high", regs[63:32], 0);
    endtask

    task automatic t_ptr_reset();
        bit a;
        logic [7:0] b;
        event_in = 8'h80; hold(1); event_in = 8'h00; hold(1);
        model[0] = 8'h80;
        chk("R8 alert after event", {31'h0, alert_oe}, 1);
        bus_start();
        send_byte(8'h95, a);
        chk("R1 read address acked", {31'h0, a}, 1);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R6 pointer at zero after reset", {24'h0, b}, 32'h80);
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h00, a);
        send_byte(8'h80, a);
        bus_stop();
        model[0] = 8'h00;
        chk("R8 flag cleared by one", {24'h0, reg_at(0)}, 0);
        chk("R8 alert released", {31'h0, alert_oe}, 0);
    endtask

    task automatic t_strap();
        bit a;
        strap = 2'b01;   // must be ignored
        bus_start();
        send_byte(8'h92, a);
        chk("R2 late strap ignored", {31'h0, a}, 0);
        send_byte(8'h55, a);
        chk("R1 off bus after mismatch", {31'h0, a}, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA4, a);
        chk("R1 wrong prefix not acked", {31'h0, a}, 0);
        bus_stop();
        bus_start();
        send_byte(8'h94, a);
        chk("R2 latched address acked", {31'h0, a}, 1);
        bus_stop();
        check_all_regs("R1 no register change");
    endtask

    task automatic t_burst_write();
        bit a;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h02, a);
        chk("R3 pointer byte acked", {31'h0, a}, 1);
        for (int i = 0; i < 4; i++) begin
            send_byte(d[i], a);
            chk("R4 data byte acked", {31'h0, a}, 1);
            model[2+i] = d[i];
        end
        bus_stop();
        check_all_regs("R10 burst write contents");
    endtask

    task automatic t_ptr_only();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h04, a);
        bus_stop();
        check_all_regs("R3 pointer-only write");
        bus_start();
        send_byte(8'h95, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R3 pointer loaded", {24'h0, b}, 32'h33);
    endtask

    task automatic t_rs_read();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h02, a);
        bus_start();   // repeated start
        send_byte(8'h95, a);
        chk("R7 read after repeated start acked", {31'h0, a}, 1);
        recv_byte(1'b1, b); chk("R5 burst read byte 0", {24'h0, b}, 32'h11);
        recv_byte(1'b1, b); chk("R5 burst read byte 1", {24'h0, b}, 32'h22);
        recv_byte(1'b0, b); chk("R5 burst read byte 2", {24'h0, b}, 32'h33);
        chk("R5 released after nack", {31'h0, sda_oe}, 0);
        bus_stop();
        bus_start();
        send_byte(8'h95, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R5 pointer moved only on acks", {24'h0, b}, 32'h33);
    endtask

    task automatic t_wrap();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h0E, a);   // upper bits ignored, pointer 6
        send_byte(8'hA6, a);
        send_byte(8'hA7, a);
        send_byte(8'h00, a);
        send_byte(8'hB1, a);
        bus_stop();
        model[6] = 8'hA6; model[7] = 8'hA7; model[1] = 8'hB1;
        check_all_regs("R6 write wrap");
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h07, a);
        bus_start();
        send_byte(8'h95, a);
        recv_byte(1'b1, b); chk("R6 read top register", {24'h0, b}, 32'hA7);
        recv_byte(1'b0, b); chk("R6 read wrapped to zero", {24'h0, b}, 32'h00);
        bus_stop();
    endtask

    task automatic t_event();
        bit a;
        event_in = 8'h05; hold(1); event_in = 8'h00; hold(1);
        chk("R8 flags set", {24'h0, reg_at(0)}, 32'h05);
        chk("R8 alert on", {31'h0, alert_oe}, 1);
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        bus_stop();
        chk("R8 partial clear", {24'h0, reg_at(0)}, 32'h04);
        chk("R8 alert still on", {31'h0, alert_oe}, 1);
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h00, a);
        send_byte(8'h04, a);
        bus_stop();
        chk("R8 all clear", {24'h0, reg_at(0)}, 0);
        chk("R8 alert off", {31'h0, alert_oe}, 0);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        hold(5);
        rst_n = 1'b1;
        hold(5);
        t_reset();
        t_ptr_reset();
        t_strap();
        t_burst_write();
        t_ptr_only();
        t_rs_read();
        t_wrap();
        t_event();
        chk("R9 sda_oe moved while SCL high", scl_hi_moves, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule